// File: doc/BRIEF.md
# Frame-Aligned Additive Bit Whitener

This block is a bit-serial additive whitener for framed links. Each frame opens with a fixed-length synchronization marker, and the marker bits pass through unchanged. Every bit after the marker is XORed with one bit from an 8-stage linear feedback sequence. That sequence is restarted from all ones on every frame. Since the operation is a plain XOR, one instance can whiten a frame before it is sent. Another instance, placed after the frame synchronizer, can restore the original bits on the receive side.

The frame synchronizer marks the first marker bit of each frame with a start-of-frame flag carried on the bit stream. Bits that arrive before the first such flag are passed through unchanged. A receiver therefore touches nothing until frame lock is declared, because a one-bit slip would corrupt a whole frame. The `mode_sel` control picks one of two feedback polynomials: 0 selects the telemetry sequence and 1 selects the telecommand sequence. The block samples it only on a start-of-frame beat. The `bypass` control turns the XOR off while the sequence keeps its count.

The stream interface is valid/ready with no storage inside. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, so back-pressure from downstream reaches the source unchanged. A beat moves only in a cycle where `in_valid` and `out_ready` are both high. `out_bit` and `out_sof` belong to that same cycle. A source may hold or drop a bit while stalled; nothing inside changes until a beat is accepted.

Top module: `frame_whitener`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. A beat is accepted when `in_valid` and `out_ready` are both 1, and `out_bit` for that beat is presented in the same cycle.
- R2: From reset until the first accepted beat with `in_sof`=1, every bit is passed through unchanged.
- R3: An accepted beat with `in_sof`=1 is the first of MARK_LEN (default 32) marker bits, and all of them pass through unchanged. An `in_sof` flag on a cycle that is not accepted has no effect.
- R4: Each accepted start-of-frame beat reloads the sequence register to all ones, including one that arrives in the middle of a frame, which then restarts the marker count.
- R5: With `mode_sel`=0 at the start-of-frame beat, data bit k (counted from 0 after the marker) is XORed with a(k). Here a(0..7)=1 and a(n+8)=a(n+7)^a(n+5)^a(n+3)^a(n), so the first 16 sequence bits are 0xFF48, MSB first.
- R6: With `mode_sel`=1 at the start-of-frame beat, a(0..7)=1 and a(n+8)=a(n+6)^a(n+4)^a(n+3)^a(n+2)^a(n+1)^a(n), so the first 16 sequence bits are 0xFF39, MSB first.
- R7: A change of `mode_sel` after the start-of-frame beat has no effect until the next start-of-frame beat.
- R8: Cycles without an accepted beat do not advance the sequence; the k-th accepted data bit always uses a(k).
- R9: While `bypass`=1, data bits pass through unchanged, but the sequence still advances by one step per accepted data bit.
- R10: Feeding a whitened frame through the block again with the same mode restores the original data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Polynomial choice, sampled at start of frame: 0 telemetry, 1 telecommand |
| bypass | input | 1 | 1 disables the XOR on data bits |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept the input beat |
| in_bit | input | 1 | Input data bit |
| in_sof | input | 1 | Marks the first marker bit of a frame |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_bit | output | 1 | Output data bit |
| out_sof | output | 1 | Start-of-frame flag carried with the output beat |

## Verification
The bound checker watches several rules on every cycle: bits pass through unchanged before lock, during the marker and under bypass; the register holds still when no beat is accepted; and it reads all ones right after each accepted start-of-frame beat. The exact sequence values for both polynomials can only be shown by the bench. So can the latching of the mode at frame start, the alignment of the sequence across random stalls and restarts, and the round trip that restores the data. The bench shows these by comparing against fixed known prefixes and against a model computed from the recurrences.

// File: rtl/whiten_pkg.sv
package whiten_pkg;

  localparam int unsigned SEQ_W    = 8;
  localparam int unsigned NUM_POLY = 2;

  typedef enum logic [0:0] {
    POLY_TLM  = 1'b0,
    POLY_TCMD = 1'b1
  } poly_e;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_MARK = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Tap masks over the window s[i] = a(n+i); feedback is the XOR of masked bits.
  localparam logic [SEQ_W-1:0] TAPS_TLM  = 8'b1010_1001;
  localparam logic [SEQ_W-1:0] TAPS_TCMD = 8'b0101_1111;

  localparam logic [NUM_POLY*SEQ_W-1:0] TAP_SET = {TAPS_TCMD, TAPS_TLM};

endpackage

// File: rtl/whiten_seqgen.sv
module whiten_seqgen #(
  parameter int unsigned W   = 8,
  parameter int unsigned NP  = 2,
  parameter logic [NP*W-1:0] TAPS = '1,
  localparam int unsigned SEL_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     state
);

  logic [W-1:0]  state_q;
  logic [NP-1:0] fb;

  for (genvar p = 0; p < NP; p++) begin : g_fb
    assign fb[p] = ^(state_q & TAPS[p*W +: W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
    end else if (load) begin
      state_q <= '1;
    end else if (step) begin
      state_q <= {fb[sel], state_q[W-1:1]};
    end
  end

  assign state = state_q;

endmodule

// File: rtl/whiten_framer.sv
module whiten_framer
  import whiten_pkg::*;
#(
  parameter int unsigned MARK_LEN = 32,
  localparam int unsigned CNT_W = $clog2(MARK_LEN + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sof,
  input  poly_e mode_in,
  output logic  is_marker,
  output logic  is_data,
  output logic  synced,
  output logic  load,
  output logic  step,
  output poly_e mode
);

  phase_e           ph_q;
  logic [CNT_W-1:0] left_q;
  poly_e            mode_q;

  always_comb begin
    is_marker = sof || (ph_q == PH_MARK);
    is_data   = !sof && (ph_q == PH_DATA);
    load      = beat && sof;
    step      = beat && is_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HUNT;
      left_q <= '0;
      mode_q <= POLY_TLM;
    end else if (beat) begin
      if (sof) begin
        mode_q <= mode_in;
        left_q <= CNT_W'(MARK_LEN - 1);
        ph_q   <= (MARK_LEN > 1) ? PH_MARK : PH_DATA;
      end else if (ph_q == PH_MARK) begin
        if (left_q == CNT_W'(1)) begin
          ph_q <= PH_DATA;
        end
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign synced = (ph_q != PH_HUNT);
  assign mode   = mode_q;

endmodule

// File: rtl/whiten_mix.sv
module whiten_mix (
  input  logic data_in,
  input  logic seq_in,
  input  logic apply,
  output logic data_out
);

  assign data_out = data_in ^ (seq_in & apply);

endmodule

// File: rtl/frame_whitener.sv
module frame_whitener
  import whiten_pkg::*;
#(
  parameter int unsigned MARK_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic bypass,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sof,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_sof
);

  logic             beat;
  logic             is_marker;
  logic             is_data;
  logic             synced;
  logic             seq_load;
  logic             seq_step;
  poly_e            mode_q;
  logic [SEQ_W-1:0] seq_q;
  logic             apply;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_sof   = in_sof;
  assign beat      = in_valid && out_ready;

  whiten_framer #(
    .MARK_LEN (MARK_LEN)
  ) framer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .sof       (in_sof),
    .mode_in   (poly_e'(mode_sel)),
    .is_marker (is_marker),
    .is_data   (is_data),
    .synced    (synced),
    .load      (seq_load),
    .step      (seq_step),
    .mode      (mode_q)
  );

  whiten_seqgen #(
    .W    (SEQ_W),
    .NP   (NUM_POLY),
    .TAPS (TAP_SET)
  ) seqgen_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seq_load),
    .step  (seq_step),
    .sel   (mode_q),
    .state (seq_q)
  );

  assign apply = is_data && !bypass;

  whiten_mix mix_i (
    .data_in  (in_bit),
    .seq_in   (seq_q[0]),
    .apply    (apply),
    .data_out (out_bit)
  );

endmodule

// File: rtl/frame_whitener_chk.sv
module frame_whitener_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_bit,
  input logic         in_sof,
  input logic         bypass,
  input logic         out_bit,
  input logic [W-1:0] seq_state,
  input logic         marker_now,
  input logic         synced
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !synced) |-> (out_bit == in_bit));

  // R3
  marker_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && marker_now) |-> (out_bit == in_bit));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof) |=> (seq_state == '1));

  // R4
  lock_after_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof) |=> synced);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(seq_state));

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |-> (out_bit == in_bit));

endmodule

bind frame_whitener frame_whitener_chk #(
  .W (whiten_pkg::SEQ_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bit     (in_bit),
  .in_sof     (in_sof),
  .bypass     (bypass),
  .out_bit    (out_bit),
  .seq_state  (seq_q),
  .marker_now (is_marker),
  .synced     (synced)
);

// File: tb/frame_whitener_tb_top.sv
module frame_whitener_tb_top;

  localparam int MARK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic bypass = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_sof = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready;
  logic out_valid;
  logic out_bit;
  logic out_sof;

  int checks = 0;
  int errors = 0;

  // bench model state, built from the requirement text
  bit         m_sync = 1'b0;
  int         m_left = 0;
  logic [7:0] m_s = 8'hFF;
  bit         m_mode = 1'b0;

  always #10 clk = ~clk;

  frame_whitener #(.MARK_LEN(MARK)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .bypass    (bypass),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_sof   (out_sof)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit next_a(bit md, logic [7:0] s);
    if (!md) return s[7] ^ s[5] ^ s[3] ^ s[0];
    return s[6] ^ s[4] ^ s[3] ^ s[2] ^ s[1] ^ s[0];
  endfunction

  function automatic logic model_out(logic b, logic sof);
    logic e;
    if (sof) begin
      e = b; m_sync = 1'b1; m_left = MARK - 1; m_s = 8'hFF; m_mode = mode_sel;
    end else if (!m_sync) begin
      e = b;
    end else if (m_left > 0) begin
      e = b; m_left--;
    end else begin
      e = b ^ (bypass ? 1'b0 : m_s[0]);
      m_s = {next_a(m_mode, m_s), m_s[7:1]};
    end
    return e;
  endfunction

  // stall cycles, then one accepted beat checked against the model
  task automatic beat(input logic b, input logic sof, input int gap,
                      input string req, output logic ob);
    logic e;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      case ($urandom % 3)
        0: begin in_valid = 1'b0; out_ready = 1'b1; end
        1: begin in_valid = 1'b1; out_ready = 1'b0; in_bit = $urandom; in_sof = $urandom; end
        default: begin in_valid = 1'b0; out_ready = 1'b0; end
      endcase
      #1;
      chk("R1 out_valid", out_valid, in_valid);
      chk("R1 in_ready", in_ready, out_ready);
    end
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1; in_bit = b; in_sof = sof;
    #1;
    e = model_out(b, sof);
    chk(req, out_bit, e);
    ob = out_bit;
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic marker(input int gapmax);
    logic ob;
    beat($urandom, 1'b1, $urandom % (gapmax + 1), "R3 marker", ob);
    for (int i = 1; i < MARK; i++) beat($urandom, 1'b0, $urandom % (gapmax + 1), "R3 marker", ob);
  endtask

  task automatic prefix_check(input bit md, input logic [15:0] pat, input int gapmax, input string req);
    logic ob;
    mode_sel = md;
    marker(gapmax);
    for (int k = 0; k < 16; k++) begin
      beat(1'b0, 1'b0, $urandom % (gapmax + 1), req, ob);
      chk(req, ob, pat[15-k]);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ob;
    logic d[$];
    logic o[$];
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out_valid", out_valid, 1'b0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    chk("R1 reset in_ready", in_ready, 1'b1);

    // R2: no frame lock yet, bits pass through
    for (int i = 0; i < 20; i++) beat($urandom, 1'b0, $urandom % 2, "R2 idle", ob);

    // R5 / R6: known prefixes with zero data
    prefix_check(1'b0, 16'hFF48, 0, "R5 tlm prefix");
    prefix_check(1'b1, 16'hFF39, 0, "R6 tcmd prefix");

    // R8: heavy stalls keep alignment
    prefix_check(1'b0, 16'hFF48, 4, "R8 stall tlm");
    prefix_check(1'b1, 16'hFF39, 4, "R8 stall tcmd");

    // R7: mode flips after start of frame are ignored
    mode_sel = 1'b0;
    marker(0);
    mode_sel = 1'b1;
    for (int k = 0; k < 16; k++) begin
      beat(1'b0, 1'b0, 0, "R7 mode latched", ob);
      chk("R7 mode latched", ob, 16'hFF48 >> (15 - k) & 1'b1);
    end

    // R9: bypass for part of the data, then sequence continues aligned
    mode_sel = 1'b0;
    marker(1);
    for (int k = 0; k < 16; k++) begin
      bypass = (k >= 4 && k < 10);
      beat(1'b0, 1'b0, 0, "R9 bypass", ob);
      chk("R9 bypass", ob, bypass ? 1'b0 : (16'hFF48 >> (15 - k) & 1'b1));
    end
    bypass = 1'b0;

    // R3: a start flag offered but not accepted is ignored
    mode_sel = 1'b1;
    marker(0);
    for (int k = 0; k < 16; k++) begin
      if (k == 8) begin
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_bit = 1'b1; out_ready = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
      end
      beat(1'b0, 1'b0, 0, "R3 sof ignored", ob);
      chk("R3 sof ignored", ob, 16'hFF39 >> (15 - k) & 1'b1);
    end

    // R4: restart in the middle of data
    mode_sel = 1'b0;
    marker(0);
    for (int k = 0; k < 5; k++) beat($urandom, 1'b0, 0, "R4 pre restart", ob);
    prefix_check(1'b0, 16'hFF48, 1, "R4 restart");

    // R10: round trip restores data
    for (int t = 0; t < 4; t++) begin
      mode_sel = t[0];
      d.delete(); o.delete();
      marker(1);
      for (int k = 0; k < 40; k++) begin
        logic b;
        b = $urandom;
        d.push_back(b);
        beat(b, 1'b0, $urandom % 2, "R10 forward", ob);
        o.push_back(ob);
      end
      marker(1);
      for (int k = 0; k < 40; k++) begin
        beat(o[k], 1'b0, $urandom % 2, "R10 reverse", ob);
        chk("R10 round trip", ob, d[k]);
      end
    end

    // random frames against the model (R5 R6 R8 R9)
    for (int f = 0; f < 60; f++) begin
      mode_sel = $urandom;
      marker(2);
      for (int k = 0; k < 20 + int'($urandom % 80); k++) begin
        bypass = ($urandom % 8 == 0);
        if (k % 7 == 3) mode_sel = $urandom;
        beat($urandom, 1'b0, $urandom % 3, "R5 R6 R8 R9 random", ob);
      end
      bypass = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule